// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block carries out one indivisible read-modify-write on a 64-bit word in an attached memory. A requester offers a command made of a major opcode, an extended opcode, a word address and two 64-bit operands. The unit reads the addressed word through a simple synchronous memory port and computes a new value from the operation. It writes that value back when the operation calls for a write. It then returns the word it read to the requester as the result.

The major opcode picks one of two families. The implicit-operand family uses no operand and offers fetch, fetch-and-clear, fetch-and-increment, fetch-and-decrement, and a decrement that commits only when its result is zero. The explicit-operand family uses operand one as the argument and offers swap, OR, AND, XOR and add. It also offers compare-and-swap, which compares memory with operand two and stores operand one only on a match. The unit takes exactly one command at a time and accepts no new command until the result of the last one has been taken. No other request can therefore reach the port between the read and the write.

Top module: `amo_unit`

## Requirements
- R1: Major opcode 0x0a selects the implicit family and 0x0c selects the explicit family. Under 0x0a, extended opcode 0x01 is a plain fetch, which returns the word and performs no memory write.
- R2: Under major 0x0a, extended 0x02 stores zero, 0x05 stores the old word plus one and 0x07 stores the old word minus one. All arithmetic wraps modulo 2^64.
- R3: Under major 0x0a, extended 0x0f computes the old word minus one. It writes that value only when the value is zero, and otherwise leaves memory unchanged.
- R4: Under major 0x0c, extended 0x00 stores operand one (swap). Extended 0x01, 0x02 and 0x03 store the old word OR, AND or XOR operand one. Extended 0x04 stores the old word plus operand one, wrapping modulo 2^64.
- R5: Under major 0x0c, extended 0x08 writes operand one only when the old word equals operand two. On a mismatch it performs no write.
- R6: For every supported operation, rspData carries the word as read before any update, and rspErr is 0.
- R7: Any other major opcode, or any other extended opcode within a family, completes with rspErr = 1 and rspData = 0. It issues neither a memory read nor a memory write.
- R8: cmdReady is low from the cycle after a command is accepted until the cycle after its result is taken. While rspValid is high and rspReady is low, rspData and rspErr hold their values.
- R9: A supported command issues exactly one read (memRe). It issues at most one write (memWe), which comes in the cycle right after the read and goes to the same address. Reads and writes never share a cycle.
- R10: During and immediately after reset, cmdReady is 1 and rspValid, memRe and memWe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit can take a command |
| cmdMajor | input | 8 | Major opcode (family) |
| cmdExt | input | 8 | Extended opcode (operation in family) |
| cmdAddr | input | ADDR_W | Word address |
| cmdOp1 | input | DATA_W | Operand one (argument / new value) |
| cmdOp2 | input | DATA_W | Operand two (compare value) |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Requester takes the result |
| rspData | output | DATA_W | Original memory word |
| rspErr | output | 1 | Unsupported command |
| memRe | output | 1 | Memory read strobe; data due next cycle |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, one cycle after memRe |

## Verification
Two events can fall in the same cycle: the requester takes a result, and the next command is already waiting on cmdValid. The bench provokes this by issuing commands back to back, with cmdValid raised while the earlier result is still pending. It also runs with a pseudo-random rspReady, so results stall for varying spans. The bench judges the overlap in three ways. Every result must match a scoreboard entry computed from a shadow copy of memory. cmdReady must be low whenever a result is being taken. The totals of memory reads and writes must equal the number the operation mix calls for, so a command accepted too early, or a lost or extra write, shows up as a data or count mismatch.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [7:0] MAJ_IMPLICIT = 8'h0a;
  localparam logic [7:0] MAJ_EXPLICIT = 8'h0c;

  typedef enum logic [3:0] {
    AMO_FETCH, AMO_CLEAR, AMO_INC, AMO_DEC, AMO_DECZ,
    AMO_SWAP, AMO_OR, AMO_AND, AMO_XOR, AMO_ADD, AMO_CAS,
    AMO_BAD
  } amoOpE;

  typedef struct packed {
    logic capture;   // latch the incoming command
    logic readPh;    // memory read issued this cycle
    logic writePh;   // read data present, update and latch result
  } amoStrobeT;

  function automatic amoOpE amoDecode(input logic [7:0] maj, input logic [7:0] ext);
    amoOpE op;
    op = AMO_BAD;
    if (maj == MAJ_IMPLICIT) begin
      case (ext)
        8'h01:   op = AMO_FETCH;
        8'h02:   op = AMO_CLEAR;
        8'h05:   op = AMO_INC;
        8'h07:   op = AMO_DEC;
        8'h0f:   op = AMO_DECZ;
        default: op = AMO_BAD;
      endcase
    end else if (maj == MAJ_EXPLICIT) begin
      case (ext)
        8'h00:   op = AMO_SWAP;
        8'h01:   op = AMO_OR;
        8'h02:   op = AMO_AND;
        8'h03:   op = AMO_XOR;
        8'h04:   op = AMO_ADD;
        8'h08:   op = AMO_CAS;
        default: op = AMO_BAD;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/amo_dpath.sv
module amo_dpath
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  amoStrobeT         strobe,
  input  logic [7:0]        cmdMajor,
  input  logic [7:0]        cmdExt,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdOp1,
  input  logic [DATA_W-1:0] cmdOp2,
  input  logic [DATA_W-1:0] memRdata,
  output logic              cmdLegal,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  amoOpE             opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] op1Q, op2Q, resQ;
  logic              errQ;
  amoOpE             opIn;
  logic [DATA_W-1:0] newVal, decVal;
  logic              wantWr;

  assign opIn     = amoDecode(cmdMajor, cmdExt);
  assign cmdLegal = (opIn != AMO_BAD);
  assign decVal   = memRdata - ONE;

  always_comb begin
    newVal = memRdata;
    wantWr = 1'b1;
    case (opQ)
      AMO_FETCH: wantWr = 1'b0;
      AMO_CLEAR: newVal = '0;
      AMO_INC:   newVal = memRdata + ONE;
      AMO_DEC:   newVal = decVal;
      AMO_DECZ: begin
        newVal = decVal;
        wantWr = (decVal == '0);
      end
      AMO_SWAP:  newVal = op1Q;
      AMO_OR:    newVal = memRdata | op1Q;
      AMO_AND:   newVal = memRdata & op1Q;
      AMO_XOR:   newVal = memRdata ^ op1Q;
      AMO_ADD:   newVal = memRdata + op1Q;
      AMO_CAS: begin
        newVal = op1Q;
        wantWr = (memRdata == op2Q);
      end
      default:   wantWr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= AMO_BAD;
      addrQ <= '0;
      op1Q  <= '0;
      op2Q  <= '0;
      resQ  <= '0;
      errQ  <= 1'b0;
    end else if (strobe.capture) begin
      opQ   <= opIn;
      addrQ <= cmdAddr;
      op1Q  <= cmdOp1;
      op2Q  <= cmdOp2;
      resQ  <= '0;
      errQ  <= !cmdLegal;
    end else if (strobe.writePh) begin
      resQ  <= memRdata;
    end
  end

  assign memWe    = strobe.writePh && wantWr;
  assign memAddr  = addrQ;
  assign memWdata = newVal;
  assign rspData  = resQ;
  assign rspErr   = errQ;

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdLegal,
  input  logic      rspReady,
  output logic      cmdReady,
  output logic      rspValid,
  output logic      memRe,
  output amoStrobeT strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_UPDATE, ST_RESP} stateE;
  stateE state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    case (state)
      ST_IDLE: if (cmdValid) begin
        strobe.capture = 1'b1;
        stateNext      = cmdLegal ? ST_READ : ST_RESP;
      end
      ST_READ: begin
        strobe.readPh = 1'b1;
        stateNext     = ST_UPDATE;
      end
      ST_UPDATE: begin
        strobe.writePh = 1'b1;
        stateNext      = ST_RESP;
      end
      ST_RESP: if (rspReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign memRe    = strobe.readPh;

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdMajor,
  input  logic [7:0]        cmdExt,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdOp1,
  input  logic [DATA_W-1:0] cmdOp2,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  amoStrobeT strobe;
  logic      cmdLegal;

  amo_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLegal(cmdLegal),
    .rspReady(rspReady), .cmdReady(cmdReady), .rspValid(rspValid),
    .memRe(memRe), .strobe(strobe)
  );

  amo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdMajor(cmdMajor),
    .cmdExt(cmdExt), .cmdAddr(cmdAddr), .cmdOp1(cmdOp1), .cmdOp2(cmdOp2),
    .memRdata(memRdata), .cmdLegal(cmdLegal), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .rspData(rspData),
    .rspErr(rspErr)
  );

endmodule

// File: rtl/amo_checker.sv
module amo_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [7:0]        cmdMajor,
  input logic [7:0]        cmdExt,
  input logic [DATA_W-1:0] cmdOp1,
  input logic [DATA_W-1:0] cmdOp2,
  input logic              rspValid,
  input logic              rspReady,
  input logic [DATA_W-1:0] rspData,
  input logic              rspErr,
  input logic              memRe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] memRdata
);

  logic [7:0]        lastMaj, lastExt;
  logic [DATA_W-1:0] lastOp1, lastOp2;
  logic              implOk, explOk, cmdBad, taken;

  assign implOk = (cmdMajor == 8'h0a) && (cmdExt == 8'h01 || cmdExt == 8'h02 ||
                  cmdExt == 8'h05 || cmdExt == 8'h07 || cmdExt == 8'h0f);
  assign explOk = (cmdMajor == 8'h0c) && (cmdExt <= 8'h04 || cmdExt == 8'h08);
  assign cmdBad = !(implOk || explOk);
  assign taken  = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastMaj <= '0; lastExt <= '0; lastOp1 <= '0; lastOp2 <= '0;
    end else if (taken) begin
      lastMaj <= cmdMajor; lastExt <= cmdExt; lastOp1 <= cmdOp1; lastOp2 <= cmdOp2;
    end
  end

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspErr)));

  assert_busy_while_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !cmdReady);

  assert_write_follows_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($past(memRe) && memAddr == $past(memAddr)));

  assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  assert_bad_cmd_no_mem_R7: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdBad) |=> (rspValid && rspErr && !memRe && !memWe));

  assert_decz_only_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && lastMaj == 8'h0a && lastExt == 8'h0f) |-> (memWdata == '0));

  assert_cas_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && lastMaj == 8'h0c && lastExt == 8'h08) |->
      (memRdata == lastOp2 && memWdata == lastOp1));

  assert_fetch_no_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lastMaj == 8'h0a && lastExt == 8'h01) |-> !memWe);

endmodule

bind amo_unit amo_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdMajor(cmdMajor), .cmdExt(cmdExt), .cmdOp1(cmdOp1), .cmdOp2(cmdOp2),
  .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspErr(rspErr),
  .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memRdata(memRdata)
);

// File: tb/sim_amo_unit.sv
`timescale 1ns/1ps
module sim_amo_unit;

  localparam int DW = 64;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [7:0]    cmdMajor = '0, cmdExt = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdOp1 = '0, cmdOp2 = '0;
  logic          rspValid;
  logic          rspReady = 1'b1;
  logic [DW-1:0] rspData;
  logic          rspErr;
  logic          memRe, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;

  always #2 clk = ~clk;

  amo_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdMajor(cmdMajor), .cmdExt(cmdExt), .cmdAddr(cmdAddr), .cmdOp1(cmdOp1),
    .cmdOp2(cmdOp2), .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspErr(rspErr), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  logic [DW-1:0] mem [NW];
  logic [DW-1:0] shadow [NW];
  int rdCount = 0, wrCount = 0, expRd = 0, expWr = 0;
  int nChecks = 0, nFails = 0;
  bit stall = 0, done = 0;
  logic [15:0] lfsr = 16'hace1;

  typedef struct { logic [DW-1:0] data; logic err; string tag; } expT;
  expT expQ[$];

  always @(posedge clk) begin
    if (memRe) begin memRdata <= mem[memAddr]; rdCount <= rdCount + 1; end
    if (memWe) begin mem[memAddr] <= memWdata; wrCount <= wrCount + 1; end
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rspReady <= stall ? (lfsr[0] & lfsr[3]) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void refOp(input logic [7:0] maj, input logic [7:0] ext,
      input logic [DW-1:0] old, input logic [DW-1:0] a, input logic [DW-1:0] b,
      output logic [DW-1:0] nv, output bit wr, output bit bad);
    nv = old; wr = 1; bad = 0;
    if (maj == 8'h0a && ext == 8'h01) wr = 0;
    else if (maj == 8'h0a && ext == 8'h02) nv = 0;
    else if (maj == 8'h0a && ext == 8'h05) nv = old + 1;
    else if (maj == 8'h0a && ext == 8'h07) nv = old - 1;
    else if (maj == 8'h0a && ext == 8'h0f) begin nv = old - 1; wr = (nv == 0); end
    else if (maj == 8'h0c && ext == 8'h00) nv = a;
    else if (maj == 8'h0c && ext == 8'h01) nv = old | a;
    else if (maj == 8'h0c && ext == 8'h02) nv = old & a;
    else if (maj == 8'h0c && ext == 8'h03) nv = old ^ a;
    else if (maj == 8'h0c && ext == 8'h04) nv = old + a;
    else if (maj == 8'h0c && ext == 8'h08) begin nv = a; wr = (old == b); end
    else begin wr = 0; bad = 1; end
  endfunction

  task automatic issue(input logic [7:0] maj, input logic [7:0] ext,
      input logic [AW-1:0] addr, input logic [DW-1:0] a, input logic [DW-1:0] b,
      input string tag);
    logic [DW-1:0] nv;
    bit wr, bad;
    expT e;
    refOp(maj, ext, shadow[addr], a, b, nv, wr, bad);
    e.data = bad ? '0 : shadow[addr];
    e.err  = bad;
    e.tag  = tag;
    if (!bad) expRd++;
    if (wr) begin shadow[addr] = nv; expWr++; end
    expQ.push_back(e);
    @(negedge clk);
    cmdValid = 1; cmdMajor = maj; cmdExt = ext; cmdAddr = addr; cmdOp1 = a; cmdOp2 = b;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic countCheck(input string req);
    check(rdCount == expRd, {req, " read count"}, DW'(rdCount), DW'(expRd));
    check(wrCount == expWr, {req, " write count"}, DW'(wrCount), DW'(expWr));
  endtask

  // monitor: scoreboard pop at the cycle the result is taken
  always @(negedge clk) begin
    if (rstN && rspValid && rspReady) begin
      if (expQ.size() == 0) begin
        check(0, "R8 unexpected result", rspData, '0);
      end else begin
        expT e;
        e = expQ.pop_front();
        check(rspData == e.data, {e.tag, " data"}, rspData, e.data);
        check(rspErr == e.err, {e.tag, " err"}, DW'(rspErr), DW'(e.err));
        check(!cmdReady, "R8 busy while result pending", DW'(cmdReady), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i]    = 64'h0123_4567_89ab_0000 + 64'(i * 16'h1111);
      shadow[i] = mem[i];
    end
    mem[3] = 64'd1;  shadow[3] = 64'd1;
    mem[4] = 64'd5;  shadow[4] = 64'd5;
    mem[5] = 64'd0;  shadow[5] = 64'd0;
    mem[6] = '1;     shadow[6] = '1;
    mem[7] = 64'h00ff_00ff_00ff_00ff; shadow[7] = mem[7];

    repeat (3) @(negedge clk);
    // R10: reset state, sampled while reset is held
    check(cmdReady && !rspValid && !memRe && !memWe, "R10 reset outputs",
          {cmdReady, rspValid, memRe, memWe}, 64'h8);
    rstN = 1;
    @(negedge clk);
    check(cmdReady && !rspValid && !memRe && !memWe, "R10 after reset",
          {cmdReady, rspValid, memRe, memWe}, 64'h8);

    // R1 plain fetch, no write
    issue(8'h0a, 8'h01, 2, 0, 0, "R1 fetch");
    drain(); countCheck("R1 fetch no write");
    // R2 clear / inc wrap / dec wrap
    issue(8'h0a, 8'h02, 2, 0, 0, "R2 clear");
    issue(8'h0a, 8'h01, 2, 0, 0, "R2 clear readback");
    issue(8'h0a, 8'h05, 6, 0, 0, "R2 inc wrap");
    issue(8'h0a, 8'h01, 6, 0, 0, "R2 inc readback");
    issue(8'h0a, 8'h07, 5, 0, 0, "R2 dec wrap");
    issue(8'h0a, 8'h01, 5, 0, 0, "R2 dec readback");
    // R3 conditional decrement
    issue(8'h0a, 8'h0f, 4, 0, 0, "R3 decz nonzero");
    issue(8'h0a, 8'h01, 4, 0, 0, "R3 decz unchanged");
    issue(8'h0a, 8'h0f, 3, 0, 0, "R3 decz to zero");
    issue(8'h0a, 8'h01, 3, 0, 0, "R3 decz readback");
    drain(); countCheck("R3 decz writes");
    // R4 explicit family
    issue(8'h0c, 8'h00, 8, 64'hdead_beef_0000_0001, 0, "R4 swap");
    issue(8'h0c, 8'h01, 7, 64'hf000_0000_0000_000f, 0, "R4 or");
    issue(8'h0c, 8'h02, 7, 64'h0ff0_0ff0_0ff0_0ff0, 0, "R4 and");
    issue(8'h0c, 8'h03, 7, 64'hffff_0000_ffff_0000, 0, "R4 xor");
    issue(8'h0c, 8'h04, 8, '1, 0, "R4 add wrap");
    issue(8'h0c, 8'h01, 8, 0, 0, "R4 readback");
    // R5 compare-and-swap
    issue(8'h0c, 8'h08, 9, 64'h5555, 64'h1, "R5 cas mismatch");
    issue(8'h0c, 8'h08, 9, 64'h5555, shadow[9], "R5 cas match");
    issue(8'h0a, 8'h01, 9, 0, 0, "R5 cas readback");
    drain(); countCheck("R5 cas writes");
    // R7 unsupported codes
    issue(8'h0b, 8'h01, 1, 0, 0, "R7 bad major");
    issue(8'h0a, 8'h03, 1, 0, 0, "R7 bad implicit ext");
    issue(8'h0c, 8'h09, 1, 64'h7, 64'h7, "R7 bad explicit ext");
    issue(8'h0a, 8'h01, 1, 0, 0, "R7 memory untouched");
    drain(); countCheck("R7 no memory access");

    // R6 / R8 / R9: back-to-back commands with stalled results
    stall = 1;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ext;
      ext = (k % 3 == 0) ? 8'h04 : (k % 3 == 1) ? 8'h08 : 8'h03;
      issue(8'h0c, ext, AW'(k % 5 + 10), 64'(k * 977 + 3), shadow[k % 5 + 10],
            "R6 stalled mix");
      issue(8'h0a, (k % 2 == 0) ? 8'h05 : 8'h0f, AW'(k % 5 + 10), 0, 0, "R8 stalled implicit");
    end
    drain();
    stall = 0;
    countCheck("R9 totals");
    for (int i = 0; i < NW; i++)
      issue(8'h0a, 8'h01, AW'(i), 0, 0, "R6 final sweep");
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule